// File: doc/BRIEF.md
# Converter Result Parallel Port

This block is a synthesizable behavioural model of the digital side of a 16-bit sampling converter. It is meant to be placed in front of a host controller under test. A falling edge on the active-low convert-start input begins a conversion. A busy flag stays high for a parameterized number of clock cycles. When busy drops, the word presented on a stimulus input is captured as the new result. No analog behaviour is modelled.

The host reads the captured word over a 16-bit tri-state data bus. The bus is driven only while both chip-select and read are low. Two runtime controls shape the word on its way out. One picks straight binary or twos-complement coding, which differ only in the sign bit. The other exchanges the two byte lanes, so an 8-bit host can fetch both halves through one lane by toggling it. Between conversions an acquisition phase of parameterized length follows. If convert-start is still held low when that phase ends, the next conversion starts by itself, so the port can free-run.

Top module: `adc_parallel_port`

## Requirements
- R1: While `cs_n` or `rd_n` is high, the block leaves every bit of `data_io` undriven (high impedance).
- R2: With `swap_bytes` low and the bus enabled, bits [7:0] of the output word appear on `data_io[7:0]` and bits [15:8] appear on `data_io[15:8]`.
- R3: With `swap_bytes` high and the bus enabled, bits [7:0] of the output word appear on `data_io[15:8]` and bits [15:8] appear on `data_io[7:0]`.
- R4: The stored sample is treated as straight binary. With `coding_twos` high, the output word is the stored sample with bit 15 inverted. With `coding_twos` low, it is the stored sample unchanged.
- R5: A falling edge of `cnv_n` while the port is idle starts a conversion. `busy` rises at the next clock edge and stays high for exactly CONV_CYCLES cycles.
- R6: A read while `busy` is high returns the previous result. The result register loads `sample_in` on the clock edge at which `busy` falls, and at no other time.
- R7: A falling edge of `cnv_n` while `busy` is high is ignored. It neither lengthens the conversion nor causes another one.
- R8: After `busy` falls, `busy` stays low for exactly ACQ_CYCLES cycles of acquisition. If `cnv_n` is low on the last acquisition cycle, `busy` rises again with no new edge. If `cnv_n` is high then, the port goes idle.
- R9: After reset, `busy` is low and the stored result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnv_n | input | 1 | Convert start, falling edge triggers, held low to free-run |
| sample_in | input | 16 | Stimulus word captured when busy falls (straight binary) |
| coding_twos | input | 1 | 1 = twos-complement output, 0 = straight binary |
| swap_bytes | input | 1 | 1 = exchange the two byte lanes |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read enable, active low |
| busy | output | 1 | High while a conversion is in progress |
| data_io | inout | 16 | Tri-state result bus |

## Verification
The output path is tried with a word whose bytes and sign bit are all distinct (0x1234), under all four combinations of coding and swap. This separates lane errors from sign-bit errors. A word with bit 15 set is also used, to catch an inversion applied to the wrong polarity. Three timing patterns are used: a single pulse start, a pulse with a second edge inserted during busy, and a held-low start. Together they tell apart the conversion length, the handling of an ignored edge, and the free-running restart after acquisition. Changing `sample_in` during busy and reading mid-conversion shows that capture happens only at the falling edge of busy.

// File: rtl/adc_port_pkg.sv
// Package: shared types for the converter result parallel port.
// Assumes: nothing beyond the standard language.
package adc_port_pkg;

    // Phases of the conversion sequencer.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CONV = 2'd1,
        PH_ACQ  = 2'd2
    } conv_phase_t;

    // Map a straight-binary word to the selected output coding.
    function automatic logic [15:0] apply_coding16(input logic [15:0] raw, input logic twos);
        apply_coding16 = {raw[15] ^ twos, raw[14:0]};
    endfunction

endpackage

// File: rtl/adc_conv_timer.sv
// Module: adc_conv_timer
// Sequences idle, conversion and acquisition phases. A falling edge of
// cnv_n accepted only when idle starts a conversion lasting CONV_CYCLES.
// An acquisition of ACQ_CYCLES follows, and at its end a low cnv_n
// restarts directly. Assumes cnv_n is synchronous to clk.
module adc_conv_timer
    import adc_port_pkg::*;
#(
    parameter int CONV_CYCLES = 12,
    parameter int ACQ_CYCLES  = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cnv_n,
    output logic busy,
    output logic capture
);
    localparam int MAX_CYC = (CONV_CYCLES > ACQ_CYCLES) ? CONV_CYCLES : ACQ_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] CONV_LOAD = CNT_W'(CONV_CYCLES - 1);
    localparam logic [CNT_W-1:0] ACQ_LOAD  = CNT_W'(ACQ_CYCLES - 1);

    conv_phase_t      phase_q, phase_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             cnv_prev_q;
    logic             start_edge;
    logic             cnt_zero;

    assign start_edge = cnv_prev_q & ~cnv_n;
    assign cnt_zero   = (cnt_q == '0);
    assign busy       = (phase_q == PH_CONV);
    assign capture    = (phase_q == PH_CONV) && cnt_zero;

    // Next phase and counter load.
    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q;
        unique case (phase_q)
            PH_IDLE: begin
                if (start_edge) begin
                    phase_d = PH_CONV;
                    cnt_d   = CONV_LOAD;
                end
            end
            PH_CONV: begin
                if (cnt_zero) begin
                    phase_d = PH_ACQ;
                    cnt_d   = ACQ_LOAD;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            PH_ACQ: begin
                if (cnt_zero) begin
                    if (!cnv_n) begin
                        phase_d = PH_CONV;
                        cnt_d   = CONV_LOAD;
                    end else begin
                        phase_d = PH_IDLE;
                    end
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: begin
                phase_d = PH_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // Phase, counter and edge-detect registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= PH_IDLE;
            cnt_q      <= '0;
            cnv_prev_q <= 1'b1;
        end else begin
            phase_q    <= phase_d;
            cnt_q      <= cnt_d;
            cnv_prev_q <= cnv_n;
        end
    end

endmodule

// File: rtl/adc_result_reg.sv
// Module: adc_result_reg
// Holds the last completed sample in straight binary. It loads on the
// capture strobe and presents the word in the selected coding.
// Assumes DATA_W >= 2. The sign bit is the top bit.
module adc_result_reg #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] sample_in,
    input  logic              coding_twos,
    output logic [DATA_W-1:0] stored_word,
    output logic [DATA_W-1:0] coded_word
);
    localparam int MSB = DATA_W - 1;

    // Result register, updated only at the end of a conversion.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stored_word <= '0;
        else if (capture)
            stored_word <= sample_in;
    end

    // Output coding: invert the sign bit for twos complement.
    always_comb begin
        coded_word      = stored_word;
        coded_word[MSB] = stored_word[MSB] ^ coding_twos;
    end

endmodule

// File: rtl/adc_bus_driver.sv
// Module: adc_bus_driver
// Places the coded word on the tri-state bus with optional exchange of the
// two halves. The bus is driven only when both selects are low.
// Assumes DATA_W is even.
module adc_bus_driver #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] word,
    input  logic              swap_bytes,
    input  logic              cs_n,
    input  logic              rd_n,
    inout  wire  [DATA_W-1:0] data_io
);
    localparam int HALF = DATA_W / 2;

    logic [DATA_W-1:0] lane_word;
    logic              drive_en;

    assign drive_en = ~cs_n & ~rd_n;

    // Lane steering per half.
    genvar g;
    generate
        for (g = 0; g < HALF; g++) begin : g_lane
            assign lane_word[g]        = swap_bytes ? word[g + HALF] : word[g];
            assign lane_word[g + HALF] = swap_bytes ? word[g]        : word[g + HALF];
        end
    endgenerate

    assign data_io = drive_en ? lane_word : {DATA_W{1'bz}};

endmodule

// File: rtl/adc_parallel_port.sv
// Module: adc_parallel_port (top)
// Converter result port: conversion sequencer, result register with
// coding select, and a tri-state byte-swappable bus driver.
// Assumes synchronous inputs and a 16-bit word by default.
module adc_parallel_port #(
    parameter int DATA_W      = 16,
    parameter int CONV_CYCLES = 12,
    parameter int ACQ_CYCLES  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnv_n,
    input  logic [DATA_W-1:0] sample_in,
    input  logic              coding_twos,
    input  logic              swap_bytes,
    input  logic              cs_n,
    input  logic              rd_n,
    output logic              busy,
    inout  wire  [DATA_W-1:0] data_io
);
    logic              capture;
    logic [DATA_W-1:0] stored_word;
    logic [DATA_W-1:0] coded_word;

    adc_conv_timer #(
        .CONV_CYCLES(CONV_CYCLES),
        .ACQ_CYCLES (ACQ_CYCLES)
    ) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnv_n  (cnv_n),
        .busy   (busy),
        .capture(capture)
    );

    adc_result_reg #(
        .DATA_W(DATA_W)
    ) result_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (capture),
        .sample_in  (sample_in),
        .coding_twos(coding_twos),
        .stored_word(stored_word),
        .coded_word (coded_word)
    );

    adc_bus_driver #(
        .DATA_W(DATA_W)
    ) bus_i (
        .word      (coded_word),
        .swap_bytes(swap_bytes),
        .cs_n      (cs_n),
        .rd_n      (rd_n),
        .data_io   (data_io)
    );

endmodule

// File: rtl/adc_parallel_port_chk.sv
// Module: adc_parallel_port_chk
// Property checker bound to adc_parallel_port. It observes ports and the
// stored result word.
module adc_parallel_port_chk #(
    parameter int DATA_W      = 16,
    parameter int CONV_CYCLES = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cnv_n,
    input logic              coding_twos,
    input logic              swap_bytes,
    input logic              cs_n,
    input logic              rd_n,
    input logic              busy,
    input logic [DATA_W-1:0] data_io,
    input logic [DATA_W-1:0] stored_word
);
    localparam int HALF = DATA_W / 2;

    int unsigned       busy_len;
    logic [DATA_W-1:0] exp_word;

    // Count consecutive busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_len <= 0;
        else if (busy) busy_len <= busy_len + 1;
        else           busy_len <= 0;
    end

    // Expected coded word seen by the host.
    always_comb begin
        exp_word           = stored_word;
        exp_word[DATA_W-1] = stored_word[DATA_W-1] ^ coding_twos;
    end

    a_r9_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!busy && stored_word == '0));

    a_r5_conv_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_len == CONV_CYCLES));

    a_r5_start_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(cnv_n));

    a_r6_update_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(stored_word) |-> $fell(busy));

    a_r2_lanes_straight: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !rd_n && !swap_bytes) |-> (data_io == exp_word));

    a_r3_lanes_swapped: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !rd_n && swap_bytes) |->
            (data_io == {exp_word[HALF-1:0], exp_word[DATA_W-1:HALF]}));

endmodule

bind adc_parallel_port adc_parallel_port_chk #(
    .DATA_W     (DATA_W),
    .CONV_CYCLES(CONV_CYCLES)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnv_n      (cnv_n),
    .coding_twos(coding_twos),
    .swap_bytes (swap_bytes),
    .cs_n       (cs_n),
    .rd_n       (rd_n),
    .busy       (busy),
    .data_io    (data_io),
    .stored_word(stored_word)
);

// File: tb/adc_parallel_port_tb_top.sv
// Directed bench for adc_parallel_port, one task per scenario.
module adc_parallel_port_tb_top;
    localparam int DW    = 16;
    localparam int CONV  = 12;
    localparam int ACQ   = 5;
    localparam logic [DW-1:0] PULL = 16'hC35A;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cnv_n;
    logic [DW-1:0] sample_in;
    logic          coding_twos;
    logic          swap_bytes;
    logic          cs_n;
    logic          rd_n;
    logic          busy;
    wire  [DW-1:0] data_bus;
    logic          tb_drv;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    // Bench drives a known pattern whenever the port should release the bus.
    assign tb_drv   = cs_n | rd_n;
    assign data_bus = tb_drv ? PULL : {DW{1'bz}};

    always #2.5 clk = ~clk;

    adc_parallel_port #(
        .DATA_W(DW), .CONV_CYCLES(CONV), .ACQ_CYCLES(ACQ)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .cnv_n(cnv_n), .sample_in(sample_in),
        .coding_twos(coding_twos), .swap_bytes(swap_bytes),
        .cs_n(cs_n), .rd_n(rd_n), .busy(busy), .data_io(data_bus)
    );

    // Watchdog.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 20000", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_checks + 1, n_fail);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Read the bus with the given controls; the result is sampled mid-phase.
    task automatic read_bus(input logic twos, input logic swp, input logic c, input logic r,
                            output logic [DW-1:0] val);
        coding_twos = twos; swap_bytes = swp; cs_n = c; rd_n = r;
        #1;
        val = data_bus;
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    // One-cycle low pulse on cnv_n; returns on the first negedge with busy up.
    task automatic start_pulse();
        @(negedge clk); cnv_n = 1'b0;
        @(negedge clk); cnv_n = 1'b1;
    endtask

    // Count negedges with busy high, starting now.
    task automatic count_busy(output int len);
        len = 0;
        while (busy && len < 200) begin len++; @(negedge clk); end
    endtask

    // Count negedges with busy low, up to a limit.
    task automatic count_idle(input int limit, output int len);
        len = 0;
        while (!busy && len < limit) begin len++; @(negedge clk); end
    endtask

    task automatic t_reset();
        logic [DW-1:0] v;
        @(negedge clk);
        check("R9 busy after reset", busy, 0);
        read_bus(0, 0, 0, 0, v);
        check("R9 result after reset", v, 16'h0000);
        read_bus(0, 0, 1, 1, v);
        check("R1 bus released at reset", v, PULL);
    endtask

    task automatic t_single_and_coding();
        logic [DW-1:0] v; int len;
        sample_in = 16'h1234;
        start_pulse();
        check("R5 busy after edge", busy, 1);
        count_busy(len);
        check("R5 conversion length", len, CONV);
        read_bus(0, 0, 0, 0, v); check("R2 straight no swap", v, 16'h1234);
        read_bus(1, 0, 0, 0, v); check("R4 twos no swap", v, 16'h9234);
        read_bus(0, 1, 0, 0, v); check("R3 straight swapped", v, 16'h3412);
        read_bus(1, 1, 0, 0, v); check("R3 R4 twos swapped", v, 16'h3492);
        read_bus(0, 0, 1, 0, v); check("R1 cs_n high", v, PULL);
        read_bus(0, 0, 0, 1, v); check("R1 rd_n high", v, PULL);
        count_idle(ACQ + 6, len);
        check("R8 idle after acq with cnv_n high", len, ACQ + 6);
    endtask

    task automatic t_read_during_busy();
        logic [DW-1:0] v; int len;
        sample_in = 16'hABCD;
        start_pulse();
        @(negedge clk);
        read_bus(0, 0, 0, 0, v);
        check("R6 read during busy gives previous", v, 16'h1234);
        sample_in = 16'h5A5A;
        @(negedge clk);
        read_bus(0, 0, 0, 0, v);
        check("R6 no capture mid-conversion", v, 16'h1234);
        count_busy(len);
        read_bus(0, 0, 0, 0, v);
        check("R6 capture at busy fall", v, 16'h5A5A);
        count_idle(ACQ + 4, len);
    endtask

    task automatic t_ignore_edge();
        int len; int idle;
        sample_in = 16'h0042;
        start_pulse();
        len = 0;
        while (busy && len < 200) begin
            len++;
            if (len == 3) cnv_n = 1'b0;
            if (len == 4) cnv_n = 1'b1;
            @(negedge clk);
        end
        check("R7 length unchanged by edge in busy", len, CONV);
        count_idle(ACQ + 6, idle);
        check("R7 no extra conversion", idle, ACQ + 6);
    endtask

    task automatic t_auto_restart();
        logic [DW-1:0] v; int len; int idle;
        sample_in = 16'h0F0F;
        @(negedge clk); cnv_n = 1'b0;
        @(negedge clk);
        count_busy(len);
        check("R5 first free-run conversion length", len, CONV);
        sample_in = 16'h7001;
        count_idle(100, idle);
        check("R8 acquisition length before restart", idle, ACQ);
        read_bus(0, 0, 0, 0, v);
        check("R6 first free-run result", v, 16'h0F0F);
        cnv_n = 1'b1;
        count_busy(len);
        check("R8 restarted conversion length", len, CONV);
        read_bus(1, 0, 0, 0, v);
        check("R4 twos with sign bit set", v, 16'hF001);
        count_idle(ACQ + 6, idle);
        check("R8 stops when cnv_n high", idle, ACQ + 6);
    endtask

    initial begin
        rst_n = 1'b0; cnv_n = 1'b1; sample_in = '0;
        coding_twos = 1'b0; swap_bytes = 1'b0; cs_n = 1'b1; rd_n = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single_and_coding();
        t_read_during_busy();
        t_ignore_edge();
        t_auto_restart();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule